// File: doc/BRIEF.md
# Breakpoint Acknowledge Cycle Sequencer

This block sits on the processor side of the external bus. It turns a breakpoint request into a read cycle in CPU address space, then acts on how that read ends. A request can come from software or from hardware. A software request carries a three-bit number taken from a breakpoint opcode. A hardware request is a pin that marks an instruction at the moment it is prefetched. That mark travels with the instruction, and the acknowledge read only starts once the marked instruction retires. A pipeline flush throws away every mark still in flight.

During the read, the block drives a fixed address pattern and holds the function code at CPU space. It then waits for a data acknowledge or a bus error; a programmable cycle limit can turn silence into a bus error. Two things decide the outcome: which way the read ended, and whether the request came from software or hardware. The outcome is one of four:

- hand the returned word to the pipeline as the next instruction;
- request an illegal-instruction exception;
- request a hardware-breakpoint exception;
- drop the breakpoint and resume.

A build-time option selects an 8-bit data port. With that port, the substituted word is assembled from two reads.

Top module: `bkpt_ack_seq`

## Requirements
- R1: While reset is high, and whenever no cycle is running, the outputs are quiet: `as_o`, `fc_o`, `addr_o` and the three outcome strobes are all zero.
- R2: For a software request, the cycle begins on the second rising edge after the request is sampled. For the whole cycle, `fc_o` is 3'b111. The address has bits [19:16] = 4'b0000, bits [4:2] = the requested number, bit 1 = 0, and every other bit 0 (bit 0 is covered by R12).
- R3: A hardware request drives `addr_o` = 24'h00001E and `fc_o` = 3'b111 for the whole cycle.
- R4: A software cycle ended by a data acknowledge drops `as_o` at that edge. In the same edge it raises `insert_valid_o` for one cycle, and `insert_word_o` holds the returned word.
- R5: A software cycle ended by a bus error raises `exc_valid_o` for one cycle, with `exc_vec_o` = 4 (illegal instruction).
- R6: A hardware cycle ended by a bus error raises `exc_valid_o` for one cycle, with `exc_vec_o` = 12 (hardware breakpoint).
- R7: A hardware cycle ended by a data acknowledge raises only `resume_o`, for one cycle. No exception and no insertion follow.
- R8: `bkpt_pin_i` tags an instruction only in a cycle where `fetch_i` is high. Tags follow prefetch order. A retire of a tagged instruction starts a hardware cycle two edges later. Untagged retires, and pin pulses without a prefetch, start nothing.
- R9: `flush_i` discards every tag not yet retired, so a later retire starts no cycle.
- R10: When `berr_i` and `dsack_i` are high in the same cycle, the bus error decides the outcome.
- R11: With `tmo_limit_i` = L (L > 0), a cycle that receives no acknowledge in its first L cycles ends as a bus error on the L-th cycle. L = 0 lets the cycle wait without limit.
- R12: With the 8-bit port, a software cycle takes two acknowledges. The first read has address bit 0 = 0 and the second has bit 0 = 1. The inserted word is {first byte, second byte}. A hardware cycle still ends on its first acknowledge.
- R13: If a software request and a tagged retire arrive in the same cycle, the hardware cycle runs first and the software cycle follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_bkpt_i | input | 1 | Software breakpoint request pulse |
| sw_num_i | input | 3 | Breakpoint number from the opcode |
| bkpt_pin_i | input | 1 | External hardware breakpoint pin |
| fetch_i | input | 1 | An instruction is prefetched this cycle |
| retire_i | input | 1 | The oldest fetched instruction finishes execution |
| flush_i | input | 1 | Pipeline flush, discards pending tags |
| tmo_limit_i | input | TMO_W | Acknowledge timeout in cycles, 0 = none |
| dsack_i | input | 1 | Data acknowledge ending the read |
| berr_i | input | 1 | Bus error ending the read |
| data_i | input | 8 or 16 | Read data (8 bits when NARROW_PORT = 1) |
| as_o | output | 1 | Acknowledge cycle in progress |
| fc_o | output | 3 | Function code |
| addr_o | output | ADDR_W | Cycle address |
| insert_valid_o | output | 1 | Returned word goes to the pipeline |
| insert_word_o | output | 16 | Word to insert |
| exc_valid_o | output | 1 | Exception request strobe |
| exc_vec_o | output | 8 | Exception vector number |
| resume_o | output | 1 | Hardware breakpoint ignored, execution continues |

## Verification
Two pairs of events can collide in one cycle.

- A tagged retire and a new software request. The bench raises `retire_i` on a tagged instruction in the same cycle as `sw_bkpt_i`. It expects the hardware address first and then the software address, each cycle ending with its own outcome.
- A data acknowledge and a bus error arriving together on one edge. The bench drives both at once and expects only an exception strobe.

A behavioural model runs alongside two instances, one with a 16-bit port and one with an 8-bit port. It compares every output on every cycle, so both the order and the exact strobe cycle are judged.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  typedef enum logic {ST_IDLE = 1'b0, ST_CYC = 1'b1} seq_state_t;
  typedef enum logic {SRC_SW = 1'b0, SRC_HW = 1'b1} bp_src_t;

  localparam logic [2:0] FC_CPU_SPACE = 3'b111;
  localparam logic [3:0] ACK_TYPE     = 4'b0000;
  localparam logic [2:0] HW_BP_NUM    = 3'b111;

endpackage

// File: rtl/bkpt_tag_fifo.sv
module bkpt_tag_fifo #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fetch_i,
  input  logic bkpt_pin_i,
  input  logic retire_i,
  input  logic flush_i,
  output logic fire_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] tag_q;
  logic [PW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q, after_pop;
  logic             pop, push;

  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pop       = retire_i && (cnt_q != '0);
  assign after_pop = cnt_q - CW'(pop);
  assign push      = fetch_i && !flush_i && (after_pop < CW'(DEPTH));
  assign fire_o    = pop && tag_q[rd_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) begin
        tag_q[wr_q] <= bkpt_pin_i;
        wr_q        <= step_ptr(wr_q);
      end
      if (pop) rd_q <= step_ptr(rd_q);
      cnt_q <= after_pop + CW'(push);
    end
  end

  // R9: after a flush, nothing is left to retire with a tag
  p_flush_drops_r9: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> !fire_o);

  // R8: occupancy never exceeds the pipeline depth
  p_depth_bound_r8: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));

endmodule

// File: rtl/bkpt_bus_seq.sv
module bkpt_bus_seq
  import bkpt_pkg::*;
#(
  parameter int NARROW_PORT = 0,
  parameter int DW          = 16,
  parameter int TMO_W       = 8,
  parameter int ADDR_W      = 24,
  parameter int ILL_VEC     = 4,
  parameter int HW_VEC      = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_req_i,
  input  logic              sw_req_i,
  input  logic [2:0]        sw_num_i,
  input  logic [TMO_W-1:0]  tmo_limit_i,
  input  logic              dsack_i,
  input  logic              berr_i,
  input  logic [DW-1:0]     data_i,
  output logic              as_o,
  output logic [2:0]        fc_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              insert_valid_o,
  output logic [15:0]       insert_word_o,
  output logic              exc_valid_o,
  output logic [7:0]        exc_vec_o,
  output logic              resume_o
);
  seq_state_t       st_q;
  bp_src_t          src_q;
  logic             hw_pend_q, sw_pend_q;
  logic [2:0]       sw_num_q;
  logic [TMO_W-1:0] tmo_cnt_q;

  logic        in_cyc, timed_out, err_end, ack_take, byte_take, ack_end, launch;
  logic        first_half;
  logic [15:0] word_now;

  function automatic logic [ADDR_W-1:0] ack_addr(input logic hw, input logic [2:0] num);
    logic [ADDR_W-1:0] a;
    a        = '0;
    a[19:16] = ACK_TYPE;
    a[4:2]   = hw ? HW_BP_NUM : num;
    a[1]     = hw;
    return a;
  endfunction

  assign in_cyc    = (st_q == ST_CYC);
  assign timed_out = (tmo_limit_i != '0) && (tmo_cnt_q == tmo_limit_i - 1'b1);
  assign err_end   = in_cyc && (berr_i || timed_out);
  assign ack_take  = in_cyc && !err_end && dsack_i;
  assign byte_take = ack_take && (src_q == SRC_SW) && first_half;
  assign ack_end   = ack_take && !byte_take;
  assign launch    = !in_cyc && (hw_pend_q || sw_pend_q);

  generate
    if (NARROW_PORT != 0) begin : g_narrow
      logic       half_q;
      logic [7:0] hi_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          half_q <= 1'b0;
          hi_q   <= '0;
        end else if (byte_take) begin
          half_q <= 1'b1;
          hi_q   <= data_i[7:0];
        end else if (err_end || ack_end) begin
          half_q <= 1'b0;
        end
      end
      assign first_half = !half_q;
      assign word_now   = {hi_q, data_i[7:0]};
    end else begin : g_wide
      assign first_half = 1'b0;
      assign word_now   = data_i[15:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q           <= ST_IDLE;
      src_q          <= SRC_SW;
      hw_pend_q      <= 1'b0;
      sw_pend_q      <= 1'b0;
      sw_num_q       <= '0;
      tmo_cnt_q      <= '0;
      as_o           <= 1'b0;
      fc_o           <= '0;
      addr_o         <= '0;
      insert_valid_o <= 1'b0;
      insert_word_o  <= '0;
      exc_valid_o    <= 1'b0;
      exc_vec_o      <= '0;
      resume_o       <= 1'b0;
    end else begin
      insert_valid_o <= 1'b0;
      exc_valid_o    <= 1'b0;
      resume_o       <= 1'b0;
      if (launch) begin
        st_q      <= ST_CYC;
        src_q     <= hw_pend_q ? SRC_HW : SRC_SW;
        as_o      <= 1'b1;
        fc_o      <= FC_CPU_SPACE;
        addr_o    <= ack_addr(hw_pend_q, sw_num_q);
        tmo_cnt_q <= '0;
        if (hw_pend_q) hw_pend_q <= 1'b0;
        else           sw_pend_q <= 1'b0;
      end else if (err_end) begin
        st_q        <= ST_IDLE;
        as_o        <= 1'b0;
        fc_o        <= '0;
        addr_o      <= '0;
        exc_valid_o <= 1'b1;
        exc_vec_o   <= (src_q == SRC_HW) ? 8'(HW_VEC) : 8'(ILL_VEC);
      end else if (byte_take) begin
        addr_o[0] <= 1'b1;
        tmo_cnt_q <= '0;
      end else if (ack_end) begin
        st_q   <= ST_IDLE;
        as_o   <= 1'b0;
        fc_o   <= '0;
        addr_o <= '0;
        if (src_q == SRC_HW) begin
          resume_o <= 1'b1;
        end else begin
          insert_valid_o <= 1'b1;
          insert_word_o  <= word_now;
        end
      end else if (in_cyc) begin
        tmo_cnt_q <= tmo_cnt_q + 1'b1;
      end
      if (hw_req_i) hw_pend_q <= 1'b1;
      if (sw_req_i && !sw_pend_q) begin
        sw_pend_q <= 1'b1;
        sw_num_q  <= sw_num_i;
      end
    end
  end

  // R1: address and function code are released between cycles
  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !as_o |-> (addr_o == '0) && (fc_o == '0));

  // R2: the function code stays in CPU space while the cycle runs
  p_cpu_space_r2: assert property (@(posedge clk) disable iff (rst)
    as_o |-> fc_o == FC_CPU_SPACE);

  // R2: a software address carries the acknowledge type and bit 1 clear
  p_sw_addr_r2: assert property (@(posedge clk) disable iff (rst)
    (as_o && src_q == SRC_SW) |-> (addr_o[1] == 1'b0) && (addr_o[19:16] == ACK_TYPE));

  // R3: the hardware address is fixed
  p_hw_addr_r3: assert property (@(posedge clk) disable iff (rst)
    (as_o && src_q == SRC_HW) |-> addr_o == ADDR_W'('h1E));

  // R4: at most one outcome is signalled per cycle
  p_one_outcome_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({insert_valid_o, exc_valid_o, resume_o}));

  // R10: a bus error seen during a cycle always produces an exception
  p_berr_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (as_o && berr_i) |=> exc_valid_o && !insert_valid_o && !resume_o);

  // R11: silence up to the limit ends the cycle with an exception
  p_timeout_r11: assert property (@(posedge clk) disable iff (rst)
    (as_o && tmo_limit_i != '0 && tmo_cnt_q == tmo_limit_i - 1'b1) |=> exc_valid_o && !as_o);

endmodule

// File: rtl/bkpt_ack_seq.sv
module bkpt_ack_seq #(
  parameter int NARROW_PORT = 0,
  parameter int TAG_DEPTH   = 4,
  parameter int TMO_W       = 8,
  parameter int ADDR_W      = 24,
  parameter int ILL_VEC     = 4,
  parameter int HW_VEC      = 12,
  localparam int DATA_W     = (NARROW_PORT != 0) ? 8 : 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_bkpt_i,
  input  logic [2:0]        sw_num_i,
  input  logic              bkpt_pin_i,
  input  logic              fetch_i,
  input  logic              retire_i,
  input  logic              flush_i,
  input  logic [TMO_W-1:0]  tmo_limit_i,
  input  logic              dsack_i,
  input  logic              berr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              as_o,
  output logic [2:0]        fc_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              insert_valid_o,
  output logic [15:0]       insert_word_o,
  output logic              exc_valid_o,
  output logic [7:0]        exc_vec_o,
  output logic              resume_o
);
  logic hw_fire;

  bkpt_tag_fifo #(.DEPTH(TAG_DEPTH)) u_tags (
    .clk        (clk),
    .rst        (rst),
    .fetch_i    (fetch_i),
    .bkpt_pin_i (bkpt_pin_i),
    .retire_i   (retire_i),
    .flush_i    (flush_i),
    .fire_o     (hw_fire)
  );

  bkpt_bus_seq #(
    .NARROW_PORT (NARROW_PORT),
    .DW          (DATA_W),
    .TMO_W       (TMO_W),
    .ADDR_W      (ADDR_W),
    .ILL_VEC     (ILL_VEC),
    .HW_VEC      (HW_VEC)
  ) u_seq (
    .clk            (clk),
    .rst            (rst),
    .hw_req_i       (hw_fire),
    .sw_req_i       (sw_bkpt_i),
    .sw_num_i       (sw_num_i),
    .tmo_limit_i    (tmo_limit_i),
    .dsack_i        (dsack_i),
    .berr_i         (berr_i),
    .data_i         (data_i),
    .as_o           (as_o),
    .fc_o           (fc_o),
    .addr_o         (addr_o),
    .insert_valid_o (insert_valid_o),
    .insert_word_o  (insert_word_o),
    .exc_valid_o    (exc_valid_o),
    .exc_vec_o      (exc_vec_o),
    .resume_o       (resume_o)
  );

endmodule

// File: tb/tb_bkpt_ack_seq.sv
`timescale 1ns/1ps

module bkpt_ref #(
  parameter int NARROW = 0,
  parameter int DEPTH  = 4,
  parameter int TW     = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sw_bkpt,
  input  logic [2:0]    sw_num,
  input  logic          pin,
  input  logic          fetch,
  input  logic          retire,
  input  logic          flush,
  input  logic [TW-1:0] limit,
  input  logic          dsack,
  input  logic          berr,
  input  logic [15:0]   data,
  output logic [54:0]   exp_v
);
  bit tags[$];
  bit busy, src_hw, hwp, swp, half, swp_old, fire, launch, terr, take;
  int num_p, cnt, hi;
  logic        as_e, iv, ev, rs;
  logic [2:0]  fc_e;
  logic [23:0] addr_e;
  logic [15:0] iw;
  logic [7:0]  evec;

  initial exp_v = '0;

  always @(posedge clk) begin
    if (rst) begin
      tags.delete();
      busy = 0; src_hw = 0; hwp = 0; swp = 0; half = 0;
      num_p = 0; cnt = 0; hi = 0;
      as_e = 0; fc_e = 0; addr_e = 0; iv = 0; iw = 0; ev = 0; evec = 0; rs = 0;
    end else begin
      iv = 0; ev = 0; rs = 0;
      swp_old = swp;
      launch = !busy && (hwp || swp);
      terr = busy && (berr || (limit != 0 && cnt == int'(limit) - 1));
      take = busy && !terr && dsack;
      if (launch) begin
        src_hw = hwp; busy = 1; as_e = 1; fc_e = 3'b111;
        addr_e = src_hw ? 24'h1E : 24'(num_p << 2);
        cnt = 0; half = 0;
        if (hwp) hwp = 0; else swp = 0;
      end else if (terr) begin
        busy = 0; as_e = 0; fc_e = 0; addr_e = 0; half = 0;
        ev = 1; evec = src_hw ? 8'd12 : 8'd4;
      end else if (take) begin
        if (!src_hw && NARROW != 0 && !half) begin
          hi = int'(data[7:0]); half = 1; addr_e[0] = 1'b1; cnt = 0;
        end else begin
          busy = 0; as_e = 0; fc_e = 0; addr_e = 0; half = 0;
          if (src_hw) rs = 1;
          else begin
            iv = 1;
            iw = (NARROW != 0) ? {8'(hi), data[7:0]} : data;
          end
        end
      end else if (busy) begin
        cnt = (cnt + 1) % (1 << TW);
      end
      fire = 0;
      if (retire && tags.size() > 0) fire = tags.pop_front();
      if (flush) tags.delete();
      else if (fetch && tags.size() < DEPTH) tags.push_back(pin);
      if (fire) hwp = 1;
      if (sw_bkpt && !swp_old) begin swp = 1; num_p = int'(sw_num); end
    end
    exp_v = {as_e, fc_e, addr_e, iv, iw, ev, evec, rs};
  end
endmodule

module tb_bkpt_ack_seq;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic rst, sw_bkpt, pin, fetch, retire, flush, dsack, berr;
  logic [2:0]  sw_num;
  logic [7:0]  limit;
  logic [15:0] data;

  logic        as_w, iv_w, ev_w, rs_w, as_n, iv_n, ev_n, rs_n;
  logic [2:0]  fc_w, fc_n;
  logic [23:0] addr_w, addr_n;
  logic [15:0] iw_w, iw_n;
  logic [7:0]  evec_w, evec_n;
  logic [54:0] exp_w, exp_n, got_w, got_n;

  int checks = 0, fails = 0;
  string phase = "R1 reset";
  bit done = 0;

  bkpt_ack_seq #(.NARROW_PORT(0)) dut (
    .clk(clk), .rst(rst), .sw_bkpt_i(sw_bkpt), .sw_num_i(sw_num), .bkpt_pin_i(pin),
    .fetch_i(fetch), .retire_i(retire), .flush_i(flush), .tmo_limit_i(limit),
    .dsack_i(dsack), .berr_i(berr), .data_i(data), .as_o(as_w), .fc_o(fc_w),
    .addr_o(addr_w), .insert_valid_o(iv_w), .insert_word_o(iw_w), .exc_valid_o(ev_w),
    .exc_vec_o(evec_w), .resume_o(rs_w));

  bkpt_ack_seq #(.NARROW_PORT(1)) dut_n (
    .clk(clk), .rst(rst), .sw_bkpt_i(sw_bkpt), .sw_num_i(sw_num), .bkpt_pin_i(pin),
    .fetch_i(fetch), .retire_i(retire), .flush_i(flush), .tmo_limit_i(limit),
    .dsack_i(dsack), .berr_i(berr), .data_i(data[7:0]), .as_o(as_n), .fc_o(fc_n),
    .addr_o(addr_n), .insert_valid_o(iv_n), .insert_word_o(iw_n), .exc_valid_o(ev_n),
    .exc_vec_o(evec_n), .resume_o(rs_n));

  bkpt_ref #(.NARROW(0)) ref_w (.clk(clk), .rst(rst), .sw_bkpt(sw_bkpt), .sw_num(sw_num),
    .pin(pin), .fetch(fetch), .retire(retire), .flush(flush), .limit(limit),
    .dsack(dsack), .berr(berr), .data(data), .exp_v(exp_w));
  bkpt_ref #(.NARROW(1)) ref_n (.clk(clk), .rst(rst), .sw_bkpt(sw_bkpt), .sw_num(sw_num),
    .pin(pin), .fetch(fetch), .retire(retire), .flush(flush), .limit(limit),
    .dsack(dsack), .berr(berr), .data(data), .exp_v(exp_n));

  assign got_w = {as_w, fc_w, addr_w, iv_w, iw_w, ev_w, evec_w, rs_w};
  assign got_n = {as_n, fc_n, addr_n, iv_n, iw_n, ev_n, evec_n, rs_n};

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (got_w !== exp_w) begin
      fails++;
      $display("FAIL %s wide port: got %h expected %h", phase, got_w, exp_w);
    end
    checks++;
    if (got_n !== exp_n) begin
      fails++;
      $display("FAIL %s R12 narrow port: got %h expected %h", phase, got_n, exp_n);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic sw_req(input logic [2:0] n);
    sw_bkpt = 1; sw_num = n; step(); sw_bkpt = 0;
  endtask

  task automatic ack2(input logic [15:0] d0, input logic [15:0] d1);
    dsack = 1; data = d0; step(); data = d1; step(); dsack = 0; data = 0;
  endtask

  task automatic err1();
    berr = 1; step(); berr = 0;
  endtask

  task automatic tag_one();
    fetch = 1; pin = 1; step(); fetch = 0; pin = 0;
  endtask

  task automatic retire1();
    retire = 1; step(); retire = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; sw_bkpt = 0; sw_num = 0; pin = 0; fetch = 0; retire = 0; flush = 0;
    dsack = 0; berr = 0; data = 0; limit = 0;
    @(negedge clk);
    idle(3);
    rst = 0;
    idle(2);

    phase = "R2 R4 sw insert";
    sw_req(3'd5); idle(3); ack2(16'h12AB, 16'h34CD); idle(3);

    phase = "R5 sw berr";
    sw_req(3'd2); idle(2); err1(); idle(2);

    phase = "R3 R7 hw resume";
    tag_one(); retire1(); idle(3); ack2(16'h5555, 16'h6666); idle(3);

    phase = "R6 hw berr";
    tag_one(); retire1(); idle(2); err1(); idle(2);

    phase = "R8 tag order";
    fetch = 1; pin = 0; step();
    pin = 1; step();
    fetch = 0; step();
    pin = 0;
    retire1(); idle(2); retire1(); idle(3); retire1(); idle(2);
    err1(); idle(2);

    phase = "R9 flush";
    tag_one(); fetch = 1; pin = 1; step(); fetch = 0; pin = 0;
    flush = 1; step(); flush = 0;
    retire1(); retire1(); idle(4);

    phase = "R10 both ends";
    sw_req(3'd7); idle(2);
    dsack = 1; berr = 1; data = 16'hBEEF; step(); dsack = 0; berr = 0; data = 0;
    idle(2);

    phase = "R11 timeout";
    limit = 8'd3; sw_req(3'd1); idle(6);
    tag_one(); retire1(); idle(6);
    limit = 8'd0; sw_req(3'd6); idle(20); ack2(16'h0F0F, 16'hF0F0); idle(2);

    phase = "R12 narrow sw";
    sw_req(3'd0); idle(1); ack2(16'h00C3, 16'h003C); idle(2);

    phase = "R13 collision";
    tag_one();
    retire = 1; sw_bkpt = 1; sw_num = 3'd4; step(); retire = 0; sw_bkpt = 0;
    idle(2); ack2(16'h1111, 16'h2222); idle(2);
    err1(); idle(3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule